// File: doc/BRIEF.md
# Write-Once Paged Flash Emulator

This block models a NOR program-flash array that firmware borrows for nonvolatile data storage. It offers a random-access 16-bit word read port, a single-word program command and a whole-page erase command. A shared command address serves both commands. Each accepted command holds the block busy for a fixed number of cycles. When that time ends, the block gives a one-cycle done strobe with either a pass flag or a fail flag.

The block enforces the storage rules of the modelled flash. An erase sets every word of one 256-word page to 0xFFFF. A program can only write a word that still reads 0xFFFF. Any program to a word holding another value fails and leaves the word unchanged, even when the new value would only clear bits that are still set. A cleared bit can return to 1 only through a page erase.

The page count is set by `PAGE_AW`. The full-size configuration uses `PAGE_AW = 7`, which gives 128 pages of 256 words (64 KB) behind a 15-bit word address. The default elaborates a smaller array of 8 pages so that builds stay light. The top address bits select the page and the low 8 bits select the word. The array contents start fully erased at reset.

Top module: `flash_emu`

## Requirements
- R1: After reset, every word reads 0xFFFF, and busy, done, pass and fail are low.
- R2: Reads are registered. `rd_data` shows the word at `rd_addr` one clock after the address is presented, and reads are allowed while a command is busy.
- R3: A program to a word reading 0xFFFF stores `prog_data` and ends with done and pass high and fail low.
- R4: A program to a word that does not read 0xFFFF ends with done and fail high. The stored word is unchanged, even when the new value only clears bits that are still 1.
- R5: An erase uses only the page field, which is the upper `PAGE_AW` bits of `cmd_addr`, and ignores the low 8 bits. It returns all 256 words of that page to 0xFFFF, leaves other pages untouched and ends with pass.
- R6: An accepted request holds busy high for exactly `BUSY_CYC` cycles. Done, together with its status, is a single-cycle pulse in the first cycle after busy falls.
- R7: Program or erase requests that arrive while busy is high are ignored. They leave the array unchanged and produce no done pulse of their own.
- R8: If program and erase requests arrive in the same accepted cycle, only the erase is performed.
- R9: Programming 0xFFFF into an erased word passes, and the word stays programmable afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; erases the whole array |
| rd_addr | input | PAGE_AW+8 | Read word address |
| rd_data | output | 16 | Read word, one cycle after `rd_addr` |
| cmd_addr | input | PAGE_AW+8 | Program word address or erase page address (page in the upper bits) |
| prog_data | input | 16 | Value to program |
| prog_req | input | 1 | Program request, taken when not busy |
| erase_req | input | 1 | Page erase request, taken when not busy; wins over `prog_req` |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| pass | output | 1 | Command succeeded (valid with done) |
| fail | output | 1 | Program rejected (valid with done) |

## Verification
The assertions assume three things about the inputs: requests are single-cycle levels, command address and data are settled when a request is taken, and nothing else depends on inputs held during busy. They check that the latched command stays fixed, which only holds if the block ignores new requests while busy. The stimulus drives every request for exactly one cycle, away from the clock edge. It waits for done before starting the next command, except in the one scenario that deliberately issues a request during busy.

// File: rtl/flash_emu.sv
module flash_emu #(
  parameter int PAGE_AW  = 3,
  parameter int WORD_AW  = 8,
  parameter int BUSY_CYC = 4,
  localparam int AW    = PAGE_AW + WORD_AW,
  localparam int WORDS = 1 << AW,
  localparam int CW    = $clog2(BUSY_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data,
  input  logic [AW-1:0] cmd_addr,
  input  logic [15:0]   prog_data,
  input  logic          prog_req,
  input  logic          erase_req,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail
);

  logic [15:0]   mem [WORDS];
  logic [AW-1:0] lat_addr;
  logic [15:0]   lat_data;
  logic          lat_erase;
  logic [CW-1:0] cnt;

  wire accept     = !busy && (prog_req || erase_req);
  wire finish     = busy && (cnt == '0);
  wire word_blank = (mem[lat_addr] == 16'hFFFF);
  wire [PAGE_AW-1:0] lat_page = lat_addr[AW-1:WORD_AW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      cnt       <= '0;
      lat_addr  <= '0;
      lat_data  <= '0;
      lat_erase <= 1'b0;
    end else begin
      done <= 1'b0;
      pass <= 1'b0;
      fail <= 1'b0;
      if (accept) begin
        busy      <= 1'b1;
        cnt       <= CW'(BUSY_CYC - 1);
        lat_addr  <= cmd_addr;
        lat_data  <= prog_data;
        lat_erase <= erase_req;
      end else if (finish) begin
        busy <= 1'b0;
        done <= 1'b1;
        pass <= lat_erase || word_blank;
        fail <= !lat_erase && !word_blank;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= 16'hFFFF;
    end else if (finish) begin
      if (lat_erase) begin
        for (int i = 0; i < (1 << WORD_AW); i++)
          mem[{lat_page, i[WORD_AW-1:0]}] <= 16'hFFFF;
      end else if (word_blank) begin
        mem[lat_addr] <= lat_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= 16'hFFFF;
    else        rd_data <= mem[rd_addr];
  end

  assert_accept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !done);
  assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy) && !busy);
  assert_status_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot({pass, fail}));
  assert_status_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !pass && !fail);
  assert_cmd_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(lat_addr) && $stable(lat_erase) && $stable(lat_data));
  assert_reprogram_fails_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (finish && !lat_erase && !word_blank) |=> fail);

endmodule

// File: tb/test_flash_emu.sv
module test_flash_emu;
  localparam int PAGE_AW = 3;
  localparam int BUSY_CYC = 4;
  localparam int AW = PAGE_AW + 8;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] rd_addr = '0, cmd_addr = '0;
  logic [15:0] rd_data, prog_data = '0;
  logic prog_req = 0, erase_req = 0;
  logic busy, done, pass, fail;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  flash_emu #(.PAGE_AW(PAGE_AW), .WORD_AW(8), .BUSY_CYC(BUSY_CYC)) i_flash_emu (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .cmd_addr(cmd_addr), .prog_data(prog_data), .prog_req(prog_req),
    .erase_req(erase_req), .busy(busy), .done(done), .pass(pass), .fail(fail));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic read_chk(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
    @(negedge clk) rd_addr = a;
    @(negedge clk) check(req, rd_data, exp);
  endtask

  // Issue one command, wait for completion, check busy length and status.
  task automatic run_cmd(input logic p, input logic e, input logic [AW-1:0] a,
                         input logic [15:0] d, input logic exp_pass, input string req);
    int n;
    @(negedge clk);
    prog_req = p; erase_req = e; cmd_addr = a; prog_data = d;
    @(negedge clk);
    prog_req = 0; erase_req = 0;
    n = 0;
    while (busy) begin
      n++;
      @(negedge clk);
    end
    check({req, " R6 busy length"}, n, BUSY_CYC);
    check({req, " R6 done"}, done, 1);
    check({req, " status pass"}, pass, exp_pass);
    check({req, " status fail"}, fail, !exp_pass);
    @(negedge clk) check({req, " R6 done one cycle"}, done, 0);
  endtask

  task automatic t_reset;
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 pass/fail", {pass, fail}, 0);
    read_chk(11'h000, 16'hFFFF, "R1 word 0");
    read_chk(11'h7FF, 16'hFFFF, "R1 last word");
    read_chk(11'h2A5, 16'hFFFF, "R1 middle word");
  endtask

  task automatic t_program;
    run_cmd(1, 0, 11'h010, 16'h1234, 1, "R3 program blank");
    read_chk(11'h010, 16'h1234, "R3 stored value");
    read_chk(11'h011, 16'hFFFF, "R2 neighbour untouched");
    run_cmd(1, 0, 11'h020, 16'hFFFE, 1, "R3 program FFFE");
  endtask

  task automatic t_reprogram;
    run_cmd(1, 0, 11'h020, 16'h7FFE, 0, "R4 clear-only reprogram");
    read_chk(11'h020, 16'hFFFE, "R4 value kept");
    run_cmd(1, 0, 11'h010, 16'h0000, 0, "R4 reprogram zero");
    read_chk(11'h010, 16'h1234, "R4 value kept 2");
  endtask

  task automatic t_read_during_busy;
    @(negedge clk);
    prog_req = 1; cmd_addr = 11'h030; prog_data = 16'hABCD; rd_addr = 11'h010;
    @(negedge clk) prog_req = 0;
    @(negedge clk) check("R2 read while busy", rd_data, 16'h1234);
    while (busy) @(negedge clk);
    @(negedge clk);
    read_chk(11'h030, 16'hABCD, "R2 read after program");
  endtask

  task automatic t_ignore_busy;
    int dones;
    @(negedge clk);
    prog_req = 1; cmd_addr = 11'h040; prog_data = 16'h5555;
    @(negedge clk);
    cmd_addr = 11'h041; prog_data = 16'h0F0F;
    @(negedge clk);
    erase_req = 1; cmd_addr = 11'h041;
    @(negedge clk);
    prog_req = 0; erase_req = 0;
    dones = 0;
    repeat (BUSY_CYC + 6) begin
      @(negedge clk);
      if (done) dones++;
    end
    check("R7 single done", dones, 1);
    read_chk(11'h040, 16'h5555, "R7 accepted program");
    read_chk(11'h041, 16'hFFFF, "R7 ignored program");
    read_chk(11'h010, 16'h1234, "R7 ignored erase");
  endtask

  task automatic t_erase;
    run_cmd(1, 0, 11'h100, 16'h0001, 1, "R5 setup a");
    run_cmd(1, 0, 11'h1FF, 16'h0002, 1, "R5 setup b");
    run_cmd(1, 0, 11'h105, 16'h0003, 1, "R5 setup c");
    run_cmd(1, 0, 11'h200, 16'h0004, 1, "R5 setup other page");
    run_cmd(0, 1, 11'h1AB, 16'h0000, 1, "R5 erase page 1");
    read_chk(11'h100, 16'hFFFF, "R5 first word erased");
    read_chk(11'h1FF, 16'hFFFF, "R5 last word erased");
    read_chk(11'h105, 16'hFFFF, "R5 mid word erased");
    read_chk(11'h200, 16'h0004, "R5 next page kept");
    read_chk(11'h010, 16'h1234, "R5 page 0 kept");
    run_cmd(1, 0, 11'h105, 16'h00AA, 1, "R5 reprogram after erase");
    read_chk(11'h105, 16'h00AA, "R5 new value");
  endtask

  task automatic t_both;
    run_cmd(1, 0, 11'h300, 16'h4444, 1, "R8 setup");
    run_cmd(1, 1, 11'h310, 16'h2222, 1, "R8 both requests");
    read_chk(11'h300, 16'hFFFF, "R8 page erased");
    read_chk(11'h310, 16'hFFFF, "R8 program dropped");
  endtask

  task automatic t_ffff;
    run_cmd(1, 0, 11'h400, 16'hFFFF, 1, "R9 program FFFF");
    read_chk(11'h400, 16'hFFFF, "R9 still blank");
    run_cmd(1, 0, 11'h400, 16'h8001, 1, "R9 program again");
    read_chk(11'h400, 16'h8001, "R9 value");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_program;
    t_reprogram;
    t_read_during_busy;
    t_ignore_busy;
    t_erase;
    t_both;
    t_ffff;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule